// File: doc/BRIEF.md
# Hypervisor Control Register Access Gate

This block decides, for every direct read or write aimed at one 64-bit hypervisor-level control register, what the access should become. It looks at the requesting exception level, a three-bit nested-virtualization control field, whether a third (monitor) level exists and whether that level has enabled fine-grained traps, and a debug condition that can make the access undefined together with a flag that sets its priority. It yields exactly one of five outcomes in the same cycle as the request: undefined, trap to level 2, trap to level 3, direct access to the real register, or redirection to a fixed slot in memory.

The gate also owns the register. When the outcome is direct access, a read returns the register contents and a write updates it at the next clock edge; the reserved upper byte always reads as zero. Exception entry, the memory access for a redirect and instruction decode upstream of the encoding compare are left to the surrounding pipeline, which consumes the one-hot outcome and the redirect offset.

Top module: `hcr_access_gate`

## Requirements
- R1: An outcome is produced only when `acc_valid` is 1 and `acc_enc` equals 16'hE08C (fields op0=2'b11, op1=3'b100, CRn=4'b0001, CRm=4'b0001, op2=3'b100 packed high to low); otherwise `outcome` is all zero.
- R2: `outcome` is one-hot in the request cycle, with bit 0 undefined, bit 1 trap to level 2, bit 2 trap to level 3, bit 3 direct access, bit 4 memory redirect.
- R3: Any access with `cur_el` = 0 is undefined.
- R4: At level 1, when `nv_ctl[0]` and `nv_ctl[2]` are both 1 (whatever `nv_ctl[1]`), the outcome is memory redirect and `redir_offset` is 12'h1B8; `redir_offset` is zero for every other outcome.
- R5: At level 1, when `nv_ctl[0]` is 1 and `nv_ctl[2]` is 0 the access traps to level 2; when `nv_ctl[0]` is 0 it is undefined.
- R6: At level 2 with `el3_present` = 1 and `el3_fg_enable` = 0, the access traps to level 3, except that it is undefined when `dbg_undef` and `dbg_undef_first` are both 1; with `dbg_undef_first` = 0 the trap wins.
- R7: At level 2 with `el3_fg_enable` = 1 or `el3_present` = 0, and at level 3 always, the outcome is direct access.
- R8: A write changes the register, visible on the next direct read, only when its outcome is direct access; writes with any other outcome leave it unchanged.
- R9: Bits 63:56 of the register are reserved: they read as zero whatever is written.
- R10: After reset the register holds zero, and `acc_rdata` is zero except during a direct-access read.
- R11: With parameter `FGT_IMPL` = 0 every recognised access is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request present this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_enc | input | 16 | Packed system-register encoding of the access |
| cur_el | input | 2 | Exception level of the requester |
| nv_ctl | input | 3 | Effective nested-virtualization bits {b2, b1, b0} |
| el3_present | input | 1 | Third level is implemented |
| el3_fg_enable | input | 1 | Fine-grained trap enable held by the third level |
| dbg_undef | input | 1 | Debug condition that can make the access undefined |
| dbg_undef_first | input | 1 | Debug condition outranks the trap to level 3 |
| acc_wdata | input | 64 | Write data |
| outcome | output | 5 | One-hot access outcome |
| acc_rdata | output | 64 | Read data on a direct read, else zero |
| redir_offset | output | 12 | Memory slot offset on a redirect, else zero |

## Verification
The assertions assume the inputs are stable and defined across each clock edge and that `cur_el` always carries a legal level; they also assume the control inputs describe one consistent machine state per cycle. The bench drives every input on the falling edge, holds it through the following rising edge, and samples the combinational outcome one nanosecond after driving, so no check straddles an edge. Level, nested-virtualization pattern and debug-flag combinations are swept exhaustively for the decision logic, while writes are issued under both permitted and refused outcomes to show that only the direct path changes stored state.

// File: rtl/hcr_gate_pkg.sv
// Package: shared constants for the access gate.
// Assumes: outcome vector bit positions are consumed by the exception pipeline.
package hcr_gate_pkg;
    localparam int OC_W        = 5;
    localparam int OC_UNDEF    = 0;
    localparam int OC_TRAP2    = 1;
    localparam int OC_TRAP3    = 2;
    localparam int OC_DIRECT   = 3;
    localparam int OC_REDIR    = 4;
    localparam int ENC_W       = 16;
    localparam logic [ENC_W-1:0] REG_ENC = {2'b11, 3'b100, 4'b0001, 4'b0001, 3'b100};
    localparam int OFS_W       = 12;
    localparam logic [OFS_W-1:0] REDIR_OFS = 12'h1B8;
    localparam int NVB_NV  = 0;
    localparam int NVB_NV1 = 1;
    localparam int NVB_NV2 = 2;
endpackage

// File: rtl/hcr_enc_match.sv
// Module: compares the access encoding with the gated register's encoding.
// Assumes: encoding fields are packed op0, op1, CRn, CRm, op2 from high to low.
module hcr_enc_match
    import hcr_gate_pkg::*;
#(
    parameter logic [ENC_W-1:0] MATCH_ENC = REG_ENC
) (
    input  logic             valid,
    input  logic [ENC_W-1:0] enc,
    output logic             hit
);
    // Recognise a valid access to the gated register.
    always_comb begin
        hit = valid && (enc == MATCH_ENC);
    end
endmodule

// File: rtl/hcr_outcome_arb.sv
// Module: chooses one of five outcomes for a recognised access.
// Assumes: inputs are settled within the cycle; the result is combinational.
module hcr_outcome_arb
    import hcr_gate_pkg::*;
#(
    parameter bit FGT_IMPL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [1:0]       cur_el,
    input  logic [2:0]       nv_ctl,
    input  logic             el3_present,
    input  logic             el3_fg_enable,
    input  logic             dbg_undef,
    input  logic             dbg_undef_first,
    output logic [OC_W-1:0]  outcome
);
    logic l1_redirect;
    logic l1_trap;
    logic l2_trap_cond;
    logic dbg_wins;

    // Derive the per-level conditions from the control inputs.
    always_comb begin
        l1_redirect  = nv_ctl[NVB_NV] && nv_ctl[NVB_NV2];
        l1_trap      = nv_ctl[NVB_NV] && !nv_ctl[NVB_NV2];
        l2_trap_cond = el3_present && !el3_fg_enable;
        dbg_wins     = dbg_undef && dbg_undef_first;
    end

    // Select the single outcome by requesting level.
    always_comb begin
        outcome = '0;
        if (hit) begin
            if (!FGT_IMPL) begin
                outcome[OC_UNDEF] = 1'b1;
            end else begin
                unique case (cur_el)
                    2'd0: outcome[OC_UNDEF] = 1'b1;
                    2'd1: begin
                        if (l1_redirect)      outcome[OC_REDIR]  = 1'b1;
                        else if (l1_trap)     outcome[OC_TRAP2]  = 1'b1;
                        else                  outcome[OC_UNDEF]  = 1'b1;
                    end
                    2'd2: begin
                        if (l2_trap_cond) begin
                            if (dbg_wins)     outcome[OC_UNDEF]  = 1'b1;
                            else              outcome[OC_TRAP3]  = 1'b1;
                        end else begin
                            outcome[OC_DIRECT] = 1'b1;
                        end
                    end
                    default: outcome[OC_DIRECT] = 1'b1;
                endcase
            end
        end
    end

    // R2
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $countones(outcome) == 1);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> outcome == '0);
    // R3
    el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cur_el == 2'd0) |-> outcome[OC_UNDEF]);
    // R6
    trap3_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outcome[OC_TRAP3] |-> (cur_el == 2'd2 && el3_present && !el3_fg_enable));
    // R4
    redir_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outcome[OC_REDIR] |-> cur_el == 2'd1);
endmodule

// File: rtl/hcr_reg_store.sv
// Module: holds the 64-bit control register with reserved bits forced to zero.
// Assumes: wr_en is asserted only for permitted direct writes.
module hcr_reg_store #(
    parameter int          DW        = 64,
    parameter logic [DW-1:0] RSVD_MASK = {8'hFF, {(DW-8){1'b0}}}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam logic [DW-1:0] KEEP_MASK = ~RSVD_MASK;

    // Update the register on a permitted write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (wr_en)  q <= wdata & KEEP_MASK;
    end

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q & RSVD_MASK) == '0);
    // R8
    hold_unless_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/hcr_access_gate.sv
// Module: top of the access gate; decodes, arbitrates and performs the access.
// Assumes: one access per cycle; outcome and read data valid in the request cycle.
module hcr_access_gate
    import hcr_gate_pkg::*;
#(
    parameter bit FGT_IMPL = 1'b1,
    parameter int DW       = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ENC_W-1:0]  acc_enc,
    input  logic [1:0]        cur_el,
    input  logic [2:0]        nv_ctl,
    input  logic              el3_present,
    input  logic              el3_fg_enable,
    input  logic              dbg_undef,
    input  logic              dbg_undef_first,
    input  logic [DW-1:0]     acc_wdata,
    output logic [OC_W-1:0]   outcome,
    output logic [DW-1:0]     acc_rdata,
    output logic [OFS_W-1:0]  redir_offset
);
    logic          hit;
    logic          wr_en;
    logic [DW-1:0] reg_q;

    hcr_enc_match u_match (
        .valid (acc_valid),
        .enc   (acc_enc),
        .hit   (hit)
    );

    hcr_outcome_arb #(.FGT_IMPL(FGT_IMPL)) u_arb (
        .clk             (clk),
        .rst_n           (rst_n),
        .hit             (hit),
        .cur_el          (cur_el),
        .nv_ctl          (nv_ctl),
        .el3_present     (el3_present),
        .el3_fg_enable   (el3_fg_enable),
        .dbg_undef       (dbg_undef),
        .dbg_undef_first (dbg_undef_first),
        .outcome         (outcome)
    );

    hcr_reg_store #(.DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wdata (acc_wdata),
        .q     (reg_q)
    );

    // Gate write enable, read data and redirect offset on the outcome.
    always_comb begin
        wr_en        = outcome[OC_DIRECT] && acc_write;
        acc_rdata    = (outcome[OC_DIRECT] && !acc_write) ? reg_q : '0;
        redir_offset = outcome[OC_REDIR] ? REDIR_OFS : '0;
    end

    // R4
    redir_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outcome[OC_REDIR] |-> redir_offset == 12'h1B8);
    // R10
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(outcome[OC_DIRECT] && !acc_write) |-> acc_rdata == '0);
    // R8
    refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_write && !outcome[OC_DIRECT]) |=> $stable(reg_q));
endmodule

// File: tb/hcr_access_gate_test.sv
module hcr_access_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [15:0] acc_enc = 16'h0;
    logic [1:0]  cur_el = 2'd0;
    logic [2:0]  nv_ctl = 3'd0;
    logic        el3_present = 1'b0, el3_fg_enable = 1'b0;
    logic        dbg_undef = 1'b0, dbg_undef_first = 1'b0;
    logic [63:0] acc_wdata = 64'h0;
    logic [4:0]  outcome, outcome_nf;
    logic [63:0] acc_rdata, rdata_nf;
    logic [11:0] redir_offset, ofs_nf;
    int vecs = 0, bad = 0;
    bit done = 1'b0;

    localparam logic [15:0] ENC = 16'hE08C;
    localparam logic [4:0] UND = 5'b00001, TR2 = 5'b00010, TR3 = 5'b00100,
                           DIR = 5'b01000, RED = 5'b10000;

    always #5 clk = ~clk;

    hcr_access_gate uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_enc(acc_enc), .cur_el(cur_el), .nv_ctl(nv_ctl),
        .el3_present(el3_present), .el3_fg_enable(el3_fg_enable),
        .dbg_undef(dbg_undef), .dbg_undef_first(dbg_undef_first),
        .acc_wdata(acc_wdata), .outcome(outcome), .acc_rdata(acc_rdata),
        .redir_offset(redir_offset));

    hcr_access_gate #(.FGT_IMPL(1'b0)) uut_nofgt (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_enc(acc_enc), .cur_el(cur_el), .nv_ctl(nv_ctl),
        .el3_present(el3_present), .el3_fg_enable(el3_fg_enable),
        .dbg_undef(dbg_undef), .dbg_undef_first(dbg_undef_first),
        .acc_wdata(acc_wdata), .outcome(outcome_nf), .acc_rdata(rdata_nf),
        .redir_offset(ofs_nf));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one access at the falling edge and let combinational outputs settle.
    task automatic drive(input logic v, input logic w, input logic [15:0] e,
                         input logic [1:0] el, input logic [2:0] nv,
                         input logic p3, input logic en, input logic du,
                         input logic df, input logic [63:0] wd);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_enc = e; cur_el = el; nv_ctl = nv;
        el3_present = p3; el3_fg_enable = en; dbg_undef = du;
        dbg_undef_first = df; acc_wdata = wd;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 16'h0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0);
    endtask

    task automatic read_direct(input string req, input logic [63:0] exp);
        drive(1'b1, 1'b0, ENC, 2'd3, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0);
        chk(req, outcome, DIR);
        chk(req, acc_rdata, exp);
    endtask

    task automatic t_reset();
        read_direct("R10 reset value", 64'h0);
        idle();
        chk("R10 idle rdata", acc_rdata, 64'h0);
    endtask

    task automatic t_recognise();
        drive(1'b0, 1'b0, ENC, 2'd3, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0);
        chk("R1 not valid", outcome, 5'b0);
        drive(1'b1, 1'b0, ENC ^ 16'h0001, 2'd3, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0);
        chk("R1 other encoding", outcome, 5'b0);
        drive(1'b1, 1'b0, ENC ^ 16'h8000, 2'd1, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0);
        chk("R1 other op0", outcome, 5'b0);
    endtask

    task automatic t_el0();
        for (int nv = 0; nv < 8; nv++) begin
            drive(1'b1, 1'b0, ENC, 2'd0, nv[2:0], 1'b1, 1'b1, 1'b0, 1'b0, 64'h0);
            chk("R3 level 0 undefined", outcome, UND);
        end
    endtask

    task automatic t_el1();
        for (int nv = 0; nv < 8; nv++) begin
            logic [4:0] e;
            logic [11:0] o;
            e = (nv[0] && nv[2]) ? RED : (nv[0] ? TR2 : UND);
            o = (nv[0] && nv[2]) ? 12'h1B8 : 12'h0;
            drive(1'b1, 1'b0, ENC, 2'd1, nv[2:0], 1'b1, 1'b0, 1'b1, 1'b1, 64'h0);
            chk("R4/R5 level 1 outcome", outcome, e);
            chk("R4 redirect offset", redir_offset, o);
            chk("R2 onehot level 1", $countones(outcome), 1);
        end
    endtask

    task automatic t_el2();
        for (int c = 0; c < 16; c++) begin
            logic p3, en, du, df;
            logic [4:0] e;
            {p3, en, du, df} = c[3:0];
            if (p3 && !en) e = (du && df) ? UND : TR3;
            else           e = DIR;
            drive(1'b1, 1'b0, ENC, 2'd2, 3'd0, p3, en, du, df, 64'h0);
            chk("R6/R7 level 2 outcome", outcome, e);
        end
        drive(1'b1, 1'b0, ENC, 2'd2, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 64'h0);
        chk("R6 trap beats low-priority debug", outcome, TR3);
    endtask

    task automatic t_el3();
        drive(1'b1, 1'b0, ENC, 2'd3, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0);
        chk("R7 level 3 direct", outcome, DIR);
    endtask

    task automatic t_write();
        drive(1'b1, 1'b1, ENC, 2'd3, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 64'hFFFF_0123_4567_89AB);
        chk("R10 rdata zero on write", acc_rdata, 64'h0);
        read_direct("R9 reserved byte cleared", 64'h00FF_0123_4567_89AB);
        drive(1'b1, 1'b1, ENC, 2'd1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h1111_1111_1111_1111);
        chk("R8 trapped write outcome", outcome, TR2);
        read_direct("R8 trapped write ignored", 64'h00FF_0123_4567_89AB);
        drive(1'b1, 1'b1, ENC, 2'd1, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 64'h2222_2222_2222_2222);
        chk("R8 redirect write outcome", outcome, RED);
        read_direct("R8 redirected write ignored", 64'h00FF_0123_4567_89AB);
        drive(1'b1, 1'b1, ENC, 2'd2, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h3333_3333_3333_3333);
        read_direct("R8 level-3 trap write ignored", 64'h00FF_0123_4567_89AB);
        drive(1'b1, 1'b1, ENC, 2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0AA5_5A5A_0000_FFFF);
        read_direct("R8 level-2 direct write", 64'h00A5_5A5A_0000_FFFF);
        drive(1'b1, 1'b0, ENC, 2'd1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0);
        chk("R10 trapped read rdata zero", acc_rdata, 64'h0);
    endtask

    task automatic t_nofgt();
        for (int el = 0; el < 4; el++) begin
            drive(1'b1, 1'b0, ENC, el[1:0], 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0);
            chk("R11 no fine-grained support undefined", outcome_nf, UND);
        end
    endtask

    initial begin
        #200_000;
        if (!done) begin
            bad++;
            vecs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_recognise();
        t_el0();
        t_el1();
        t_el2();
        t_el3();
        t_write();
        t_nofgt();
        idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule